// File: doc/BRIEF.md
# UART receiver with selectable idle-line detection

This block receives asynchronous serial characters from an RX pin. The line passes through a synchroniser and is examined once per strobe of an oversampling tick that runs at `OVS` times the baud rate. A character has a start bit, 8 or 9 data bits sent least-significant first, an optional parity bit and one stop bit. Each received character comes out on a parallel data bus together with a one-cycle valid strobe and its parity-error and framing-error flags.

Alongside the framer, an idle detector counts bit periods of logic 1. When that count reaches one full character length, the block raises a one-cycle idle pulse. A mode input selects where counting begins. With the mode at 0, counting starts right after the start bit, so data ones count. With the mode at 1, counting starts at the stop bit. A receiver-wakeup input overrides that choice and forces counting from the start bit. A pulse fires at most once per idle period, and the detector re-arms only when a new character arrives.

The framer is one state machine with five states. LINE watches for a falling edge. START checks the line at mid-bit. DATA shifts in the data bits. PARITY captures the parity bit. STOP samples the stop bit. The transitions are:
- LINE to START on a falling edge.
- START to LINE if the mid-bit sample is high (a glitch).
- START to DATA if the mid-bit sample is low.
- DATA to PARITY after the last data bit when parity is on.
- DATA to STOP after the last data bit when parity is off.
- PARITY to STOP after the parity sample.
- STOP to LINE after the stop sample.

Top module: `sercom_rx`

## Requirements
- R1: After a synchronous active-high reset, all outputs are 0. A start is taken only on a high-to-low transition, so a line that is already low when reset is released produces no character.
- R2: A start bit is confirmed only if the line is still low at the mid-bit sample. A low pulse shorter than half a bit delivers nothing.
- R3: Each character raises `rx_valid` for exactly one cycle. Data bits are taken least-significant bit first. In 8-bit mode the data sits on `rx_data[7:0]` and `rx_data[8]` is 0.
- R4: The data length is 9 bits when `fmt_nine`=1, unless `fmt_par_en`=1 and `fmt_ten`=0. In that case the parity bit takes the 9th slot and only 8 data bits are received. In every other case the data length is 8 bits.
- R5: When parity is enabled, the parity bit is the bit just before the stop bit. With `fmt_par_odd`=0 (even parity), the expected parity bit is 1 exactly when the data has an odd number of ones. With `fmt_par_odd`=1 (odd parity), the rule is inverted. On a mismatch, `rx_perr`=1 for that character. With parity disabled, `rx_perr` stays 0.
- R6: A stop bit sampled as 0 sets `rx_ferr` for that character. The character is still delivered with its strobe.
- R7: `rx_data`, `rx_perr` and `rx_ferr` change only in a cycle where `rx_valid` is 1, and they hold between strobes.
- R8: The idle length equals the character length: 2 bits plus the data bits plus 1 if parity is enabled. This gives 10, 11 or 12 bit periods.
- R9: With `idle_after_stop`=0, ones are counted from the first data bit onward. A character of all-one data followed by a high line therefore gives an idle pulse one bit period after the stop sample.
- R10: With `idle_after_stop`=1, ones inside a character are not counted and the stop bit restarts the count from zero. The idle pulse then comes a full idle length of bit periods after the stop sample.
- R11: With `wake_idle`=1, the setting of `idle_after_stop` has no effect, and counting behaves as in R9.
- R12: `rx_idle` is a one-cycle pulse, never in the same cycle as `rx_valid`. It fires at most once between two received characters, and not at all before the first character after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle strobe at OVS times the baud rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| fmt_nine | input | 1 | Selects 9-bit characters |
| fmt_par_en | input | 1 | Enables the parity bit |
| fmt_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fmt_ten | input | 1 | Keeps 9 data bits when parity is also enabled |
| idle_after_stop | input | 1 | 1 = idle count starts at the stop bit, 0 = after the start bit |
| wake_idle | input | 1 | Idle-line wakeup active; overrides idle_after_stop |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_perr | output | 1 | Parity error of the last character |
| rx_ferr | output | 1 | Framing error of the last character |
| rx_idle | output | 1 | One-cycle idle-line pulse |

## Verification
The bound checker watches the output protocol on every cycle: the valid and idle pulses last a single cycle and never coincide, the result fields hold between strobes, the outputs are quiet after reset, and there is no second idle pulse without an intervening character. Only the bench scenarios can show the rest. These are the bit ordering and data length per format, the parity rule, glitch rejection and the framing flag. They also include where the idle pulse lands in time under each counting mode and idle length. The bench checks these by comparing every strobe against a queue of expected characters and by counting idle pulses inside bit-time windows.

// File: rtl/sercom_rx_pkg.sv
package sercom_rx_pkg;

    localparam int DATA_MAX = 9;
    localparam int LEN_W    = 4;

    typedef enum logic [2:0] {
        ST_LINE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic ten;
    } rx_fmt_t;

    // Data bits per character for a given format.
    function automatic logic [LEN_W-1:0] data_len(rx_fmt_t f);
        if (f.nine && !(f.par_en && !f.ten))
            return LEN_W'(DATA_MAX);
        return LEN_W'(8);
    endfunction

    // Whole character length in bit periods (start + data + parity + stop).
    function automatic logic [LEN_W-1:0] frame_len(rx_fmt_t f);
        return data_len(f) + LEN_W'(2) + LEN_W'(f.par_en);
    endfunction

endpackage

// File: rtl/sercom_rx_sync.sv
module sercom_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sercom_rx_fsm.sv
module sercom_rx_fsm
    import sercom_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                rx_s,
    input  rx_fmt_t             fmt,
    input  logic                par_odd,
    output logic                ev_start,
    output logic                ev_bit,
    output logic                ev_stop,
    output logic                ev_line,
    output logic                ev_val,
    output logic [DATA_MAX-1:0] data_o,
    output logic                valid_o,
    output logic                perr_o,
    output logic                ferr_o
);
    localparam int PH_W = $clog2(OVS);
    localparam int NB_W = $clog2(DATA_MAX + 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

    rx_state_t             state, nxt;
    logic [PH_W-1:0]       ph;
    logic [NB_W-1:0]       nbits;
    logic [DATA_MAX-1:0]   shreg;
    logic                  par_bit;
    logic                  rx_prev;
    logic [LEN_W-1:0]      dlen;
    logic                  at_mid, at_last, fall, last_data;
    logic [DATA_MAX-1:0]   word;
    logic                  exp_par;

    assign dlen      = data_len(fmt);
    assign at_mid    = tick && (ph == PH_MID);
    assign at_last   = tick && (ph == PH_LAST);
    assign fall      = tick && rx_prev && !rx_s;
    assign last_data = (nbits + 1'b1) == NB_W'(dlen);
    // Bits enter at the top, so a short character is right-aligned by shifting.
    assign word      = shreg >> (DATA_MAX - int'(dlen));
    assign exp_par   = (^word) ^ par_odd;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_LINE;
        else
            state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LINE:   if (fall)    nxt = ST_START;
            ST_START:  if (at_mid)  nxt = rx_s ? ST_LINE : ST_DATA;
            ST_DATA:   if (at_last && last_data)
                                    nxt = fmt.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_last) nxt = ST_STOP;
            ST_STOP:   if (at_last) nxt = ST_LINE;
            default:                nxt = ST_LINE;
        endcase
    end

    // Bit timing and shift datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= '0;
            nbits   <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            rx_prev <= 1'b0;
        end else begin
            if (tick)
                rx_prev <= rx_s;
            if (state != nxt)
                ph <= '0;
            else if (tick)
                ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
            if (state == ST_START)
                nbits <= '0;
            else if (state == ST_DATA && at_last) begin
                nbits <= nbits + 1'b1;
                shreg <= {rx_s, shreg[DATA_MAX-1:1]};
            end
            if (state == ST_PARITY && at_last)
                par_bit <= rx_s;
        end
    end

    // Sampling events for the idle detector
    assign ev_start = (state == ST_START) && at_mid && !rx_s;
    assign ev_bit   = (state == ST_DATA || state == ST_PARITY) && at_last;
    assign ev_stop  = (state == ST_STOP) && at_last;
    assign ev_line  = (state == ST_LINE) && at_last && !fall;
    assign ev_val   = rx_s;

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= ev_stop;
            if (ev_stop) begin
                data_o <= word;
                perr_o <= fmt.par_en && (par_bit != exp_par);
                ferr_o <= !rx_s;
            end
        end
    end
endmodule

// File: rtl/sercom_rx_idle.sv
module sercom_rx_idle
    import sercom_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_fmt_t fmt,
    input  logic    after_stop,
    input  logic    wake,
    input  logic    ev_start,
    input  logic    ev_bit,
    input  logic    ev_stop,
    input  logic    ev_line,
    input  logic    ev_val,
    output logic    idle_o
);
    logic [LEN_W-1:0] run, run_nx, run_inc, lim;
    logic             armed, count_frame, hit;

    assign lim         = frame_len(fmt);
    assign count_frame = !after_stop || wake;
    assign run_inc     = (run >= lim) ? run : run + 1'b1;

    always_comb begin
        run_nx = run;
        if (ev_start)
            run_nx = '0;
        else if (ev_bit || ev_stop)
            run_nx = (count_frame && ev_val) ? run_inc : '0;
        else if (ev_line)
            run_nx = ev_val ? run_inc : '0;
    end

    assign hit = armed && (run_nx == lim) && (run < lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= '0;
            armed  <= 1'b0;
            idle_o <= 1'b0;
        end else begin
            run    <= run_nx;
            idle_o <= hit;
            if (ev_stop)
                armed <= 1'b1;
            else if (hit)
                armed <= 1'b0;
        end
    end
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                os_tick,
    input  logic                rxd,
    input  logic                fmt_nine,
    input  logic                fmt_par_en,
    input  logic                fmt_par_odd,
    input  logic                fmt_ten,
    input  logic                idle_after_stop,
    input  logic                wake_idle,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                rx_idle
);
    rx_fmt_t fmt;
    logic    rx_s;
    logic    ev_start, ev_bit, ev_stop, ev_line, ev_val;

    assign fmt = '{nine: fmt_nine, par_en: fmt_par_en, ten: fmt_ten};

    sercom_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rx_s)
    );

    sercom_rx_fsm #(.OVS(OVS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .rx_s     (rx_s),
        .fmt      (fmt),
        .par_odd  (fmt_par_odd),
        .ev_start (ev_start),
        .ev_bit   (ev_bit),
        .ev_stop  (ev_stop),
        .ev_line  (ev_line),
        .ev_val   (ev_val),
        .data_o   (rx_data),
        .valid_o  (rx_valid),
        .perr_o   (rx_perr),
        .ferr_o   (rx_ferr)
    );

    sercom_rx_idle u_idle (
        .clk        (clk),
        .rst        (rst),
        .fmt        (fmt),
        .after_stop (idle_after_stop),
        .wake       (wake_idle),
        .ev_start   (ev_start),
        .ev_bit     (ev_bit),
        .ev_stop    (ev_stop),
        .ev_line    (ev_line),
        .ev_val     (ev_val),
        .idle_o     (rx_idle)
    );
endmodule

// File: rtl/sercom_rx_chk.sv
module sercom_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic [8:0] rx_data,
    input logic       rx_valid,
    input logic       rx_perr,
    input logic       rx_ferr,
    input logic       rx_idle
);
    // Set while an idle pulse has been given (or since reset) and no character followed.
    logic idle_lock;

    always_ff @(posedge clk) begin
        if (rst)
            idle_lock <= 1'b1;
        else if (rx_valid)
            idle_lock <= 1'b0;
        else if (rx_idle)
            idle_lock <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rx_valid && !rx_idle && !rx_perr && !rx_ferr));

    a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r7_fields_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_perr) && $stable(rx_ferr)));

    a_r12_idle_single: assert property (@(posedge clk) disable iff (rst)
        rx_idle |=> !rx_idle);

    a_r12_idle_apart: assert property (@(posedge clk) disable iff (rst)
        !(rx_idle && rx_valid));

    a_r12_idle_once: assert property (@(posedge clk) disable iff (rst)
        rx_idle |-> !idle_lock);
endmodule

bind sercom_rx sercom_rx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_perr  (rx_perr),
    .rx_ferr  (rx_ferr),
    .rx_idle  (rx_idle)
);

// File: tb/test_sercom_rx.sv
module test_sercom_rx;
    localparam int BIT_CLK = 32;   // 16 ticks per bit, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       fmt_nine = 1'b0, fmt_par_en = 1'b0, fmt_par_odd = 1'b0, fmt_ten = 1'b0;
    logic       idle_after_stop = 1'b0, wake_idle = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr, rx_idle;

    int checks = 0, fails = 0;
    int idle_seen = 0, valid_seen = 0;
    logic [10:0] exp_q[$];
    string       tag_q[$];
    logic [10:0] e_word;
    string       e_tag;

    sercom_rx i_sercom_rx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .fmt_nine(fmt_nine), .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd),
        .fmt_ten(fmt_ten), .idle_after_stop(idle_after_stop), .wake_idle(wake_idle),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_idle(rx_idle)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            os_tick = ~os_tick;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference model: every strobe is compared against the expected-character queue.
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_idle) idle_seen++;
            if (rx_valid) begin
                valid_seen++;
                if (exp_q.size() == 0)
                    check(1'b0, "R3", "unexpected strobe", int'(rx_data), -1);
                else begin
                    e_word = exp_q.pop_front();
                    e_tag  = tag_q.pop_front();
                    check({rx_ferr, rx_perr, rx_data} == e_word, e_tag,
                          "char {ferr,perr,data}", int'({rx_ferr, rx_perr, rx_data}),
                          int'(e_word));
                end
            end
        end
    end

    task automatic wait_bits(input int n);
        repeat (n * BIT_CLK) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_char(input logic [8:0] d, input bit good_par,
                             input bit stop, input string tag);
        int         nd;
        logic [8:0] dm;
        logic       pbit;
        nd   = (fmt_nine && !(fmt_par_en && !fmt_ten)) ? 9 : 8;
        dm   = (nd == 9) ? d : {1'b0, d[7:0]};
        pbit = ($countones(dm) % 2 == 1) ^ fmt_par_odd;
        if (!good_par) pbit = ~pbit;
        exp_q.push_back({~stop, fmt_par_en & ~good_par, dm});
        tag_q.push_back(tag);
        send_bit(1'b0);
        for (int i = 0; i < nd; i++) send_bit(dm[i]);
        if (fmt_par_en) send_bit(pbit);
        send_bit(stop);
        rxd = 1'b1;
    endtask

    task automatic idle_window(input int bits, output int n);
        int s;
        s = idle_seen;
        wait_bits(bits);
        n = idle_seen - s;
    endtask

    initial begin
        int n, v0;
        repeat (3) @(negedge clk);
        check(rx_valid == 0 && rx_idle == 0 && rx_perr == 0 && rx_ferr == 0,
              "R1", "outputs in reset", int'({rx_valid, rx_idle, rx_perr, rx_ferr}), 0);
        check(rx_data == 0, "R1", "data in reset", int'(rx_data), 0);
        rst = 1'b0;

        // R12: no idle pulse before the first character
        idle_window(15, n);
        check(n == 0, "R12", "idle before first char", n, 0);

        // R3: 8N1 characters, LSB first
        send_char(9'h055, 1, 1, "R3");
        send_char(9'h0A3, 1, 1, "R3");
        send_char(9'h000, 1, 1, "R3");
        send_char(9'h0FF, 1, 1, "R3");
        wait_bits(2);
        check(valid_seen == 4, "R3", "strobe count", valid_seen, 4);

        // R2: short low glitch is rejected
        v0 = valid_seen;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        wait_bits(14);
        check(valid_seen == v0, "R2", "glitch produced char", valid_seen - v0, 0);

        // R5: even and odd parity
        fmt_par_en = 1'b1;
        send_char(9'h037, 1, 1, "R5");
        send_char(9'h037, 0, 1, "R5");
        fmt_par_odd = 1'b1;
        send_char(9'h081, 1, 1, "R5");
        send_char(9'h081, 0, 1, "R5");
        fmt_par_odd = 1'b0;
        wait_bits(2);

        // R4: 9-bit formats
        fmt_par_en = 1'b0; fmt_nine = 1'b1;
        wait_bits(1);
        send_char(9'h1A5, 1, 1, "R4");
        send_char(9'h0FF, 1, 1, "R4");
        fmt_par_en = 1'b1; fmt_ten = 1'b1;
        wait_bits(1);
        send_char(9'h155, 1, 1, "R4");
        send_char(9'h155, 0, 1, "R4");
        fmt_ten = 1'b0;
        wait_bits(1);
        send_char(9'h0C3, 1, 1, "R4");
        fmt_nine = 1'b0; fmt_par_en = 1'b0;
        wait_bits(2);

        // R6 / R7: framing error delivered and held
        send_char(9'h03C, 1, 0, "R6");
        wait_bits(3);
        check(rx_ferr == 1 && rx_data == 9'h03C, "R7", "ferr/data held",
              int'({rx_ferr, rx_data}), int'({1'b1, 9'h03C}));
        send_char(9'h0C5, 1, 1, "R7");
        wait_bits(2);
        check(rx_ferr == 0, "R7", "ferr cleared by good char", int'(rx_ferr), 0);
        wait_bits(15);

        // R9: count after start bit, all-ones data
        send_char(9'h0FF, 1, 1, "R9");
        idle_window(3, n);
        check(n == 1, "R9", "early idle pulse", n, 1);
        // R12: once per idle period
        idle_window(30, n);
        check(n == 0, "R12", "repeat idle pulse", n, 0);

        // R10: count after stop bit
        idle_after_stop = 1'b1;
        send_char(9'h0FF, 1, 1, "R10");
        idle_window(3, n);
        check(n == 0, "R10", "idle too early", n, 0);
        idle_window(9, n);
        check(n == 1, "R10", "idle after 10 bits", n, 1);

        // R8: 11-bit character length
        fmt_par_en = 1'b1;
        send_char(9'h012, 1, 1, "R8");
        idle_window(10, n);
        check(n == 0, "R8", "11-bit idle too early", n, 0);
        idle_window(3, n);
        check(n == 1, "R8", "11-bit idle pulse", n, 1);

        // R8: 12-bit character length
        fmt_nine = 1'b1; fmt_ten = 1'b1;
        send_char(9'h1FF, 1, 1, "R8");
        idle_window(11, n);
        check(n == 0, "R8", "12-bit idle too early", n, 0);
        idle_window(3, n);
        check(n == 1, "R8", "12-bit idle pulse", n, 1);
        fmt_nine = 1'b0; fmt_ten = 1'b0; fmt_par_en = 1'b0;

        // R11: wakeup overrides the count-after-stop choice
        wake_idle = 1'b1;
        send_char(9'h0FF, 1, 1, "R11");
        idle_window(3, n);
        check(n == 1, "R11", "wakeup idle pulse", n, 1);
        wake_idle = 1'b0; idle_after_stop = 1'b0;
        wait_bits(12);

        // R1: line low at reset release, then high: no start
        rst = 1'b1; rxd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        v0 = valid_seen;
        wait_bits(20);
        rxd = 1'b1;
        wait_bits(3);
        check(valid_seen == v0, "R1", "char without falling edge", valid_seen - v0, 0);
        send_char(9'h05A, 1, 1, "R1");
        wait_bits(2);
        check(valid_seen == v0 + 1, "R1", "char after release", valid_seen - v0, 1);

        check(exp_q.size() == 0, "R3", "missing strobes", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule